// File: doc/BRIEF.md
# SRAM Bank Power Gating Controller

This block sits between a simple single-cycle memory bus and a banked SRAM whose banks are 8 KB each. It decides which banks are powered and which keep their contents in deep sleep. It also screens every bus access against the current power state. Software programs two small registers. One is a bank-enable mask, which the block always widens downward so the powered region is a contiguous run from bank zero upward. The other is a retention mask, which takes effect only on banks that are enabled. Bank zero can never be switched off, and it is always retained.

Reads aimed at a switched-off bank return zero and never reach the array. Writes aimed at one are dropped. Whenever the effective enable vector changes, the block raises a stall for a fixed number of cycles and keeps all array requests low during that window. A deep-sleep input moves the per-bank power outputs from the enable set to the retained set.

Top module: `sbpg_ctrl`

## Requirements
- R1: After reset the effective enable vector is 0x01, the effective retention vector is 0x01, bus_stall is low, and bank_pwr and bank_ret are both 0x01.
- R2: A write to register offset 0 (enable) stores the value with every bit below its highest set bit filled in, and with bit 0 always set. Writing 0x20 gives 0x3F and writing 0x00 gives 0x01. A read of offset 0 returns the stored vector.
- R3: A write to register offset 1 (retention) stores the value with bit 0 forced to 1, and a read of offset 1 returns it. The effective retention vector is the stored value ANDed with the effective enable vector, so a retention bit for a disabled bank has no effect.
- R4: Register offset 2 is read-only status. Bits [7:0] hold the effective enable vector, bits [15:8] hold the effective retention vector, and bit 16 is a busy flag that equals bus_stall.
- R5: When a register write changes the effective enable vector, bus_stall is high for exactly STALL_CYCLES (default 4) consecutive cycles. The first of these cycles is the one in which the new vector takes effect. A write that leaves the vector unchanged causes no stall.
- R6: A further change of the effective enable vector while a stall is running restarts the count, so the stall ends STALL_CYCLES cycles after the latest change.
- R7: While bus_stall is high, mem_req stays low whatever the bus does.
- R8: A bus read whose address bits [15:13] select a disabled bank issues no mem_req, and in the following cycle bus_rdata is zero.
- R9: A bus write to a disabled bank issues no mem_req, so the array contents are unchanged when the bank is enabled later.
- R10: A bus access to an enabled bank while not stalled drives mem_req with the bus address, direction and write data unchanged. A read's data appears on bus_rdata in the next cycle.
- R11: With lp_deep low, bank_pwr equals the effective enable vector. With lp_deep high, bank_pwr equals the effective retention vector. A disabled bank is never powered in either mode.
- R12: bank_ret equals the effective retention vector, and bit 0 of both bank_pwr and bank_ret is always 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register offset: 0 enable, 1 retention, 2 status |
| reg_wdata | input | 8 | Register write data, one bit per bank |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| lp_deep | input | 1 | High while the system is in deep low-power mode |
| bus_req | input | 1 | Bus access request |
| bus_we | input | 1 | Bus write (1) or read (0) |
| bus_addr | input | 16 | Bus byte address; bits [15:13] select the bank |
| bus_wdata | input | 32 | Bus write data |
| bus_rdata | output | 32 | Bus read data, valid the cycle after a read |
| bus_stall | output | 1 | Accesses must be held while high |
| mem_req | output | 1 | Array access request |
| mem_we | output | 1 | Array write enable |
| mem_addr | output | 16 | Array address |
| mem_wdata | output | 32 | Array write data |
| mem_rdata | input | 32 | Array read data, one cycle after mem_req |
| bank_pwr | output | 8 | Per-bank power-on |
| bank_ret | output | 8 | Per-bank retention |

## Verification
The hardest case to reach from the ports is a stall restart. It needs a second enable change to land inside a running stall window, and the stall length must still be counted from that second change. The bench lets one write's stall run for two cycles, then issues another write that changes the vector, and samples bus_stall every cycle until the extended window closes. A related hard case is proving that a write to a disabled bank was dropped rather than just hidden. The bench writes into a disabled bank, widens the enable set to cover it, waits out the stall, and reads back the array's original preset value.

// File: rtl/sbpg_pkg.sv
package sbpg_pkg;

    localparam int SB_BANKS   = 8;
    localparam int SB_BANK_AW = 13;
    localparam int SB_SEL_W   = $clog2(SB_BANKS);
    localparam int SB_ADDR_W  = SB_BANK_AW + SB_SEL_W;
    localparam int SB_DATA_W  = 32;
    localparam int SB_STALL   = 4;

    typedef enum logic [1:0] {
        RG_ENABLE = 2'd0,
        RG_RETAIN = 2'd1,
        RG_STATUS = 2'd2
    } reg_sel_e;

    typedef struct packed {
        logic rd;
        logic wr;
        logic hit;
    } acc_t;

    function automatic logic [SB_BANKS-1:0] fill_down(input logic [SB_BANKS-1:0] v);
        logic [SB_BANKS-1:0] r;
        r[SB_BANKS-1] = v[SB_BANKS-1];
        for (int i = SB_BANKS - 2; i >= 0; i--) begin
            r[i] = v[i] | r[i+1];
        end
        r[0] = 1'b1;
        return r;
    endfunction

endpackage

// File: rtl/sbpg_regs.sv
module sbpg_regs
    import sbpg_pkg::*;
#(
    parameter int NB = SB_BANKS,
    parameter int DW = SB_DATA_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          reg_wr,
    input  logic [1:0]    reg_addr,
    input  logic [NB-1:0] reg_wdata,
    input  logic          busy,
    output logic [NB-1:0] en_eff,
    output logic [NB-1:0] ret_eff,
    output logic          en_chg,
    output logic [DW-1:0] reg_rdata
);
    localparam logic [NB-1:0] BANK0 = NB'(1);

    logic [NB-1:0] en_q, ret_q, en_next;
    reg_sel_e      sel;

    assign sel     = reg_sel_e'(reg_addr);
    assign en_next = fill_down(reg_wdata);

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q   <= BANK0;
            ret_q  <= BANK0;
            en_chg <= 1'b0;
        end else begin
            en_chg <= 1'b0;
            if (reg_wr && sel == RG_ENABLE) begin
                en_q   <= en_next;
                en_chg <= (en_next != en_q);
            end
            if (reg_wr && sel == RG_RETAIN) begin
                ret_q <= reg_wdata | BANK0;
            end
        end
    end

    assign en_eff  = en_q;
    assign ret_eff = ret_q & en_q;

    always_comb begin
        reg_rdata = '0;
        unique case (sel)
            RG_ENABLE: reg_rdata[NB-1:0] = en_q;
            RG_RETAIN: reg_rdata[NB-1:0] = ret_q;
            RG_STATUS: begin
                reg_rdata[NB-1:0]    = en_q;
                reg_rdata[2*NB-1:NB] = ret_eff;
                reg_rdata[2*NB]      = busy;
            end
            default: reg_rdata = '0;
        endcase
    end

    p_contig_r2: assert property (@(posedge clk) disable iff (rst)
        (((en_q + NB'(1)) & en_q) == '0) && en_q[0]);

    p_bank0_kept_r12: assert property (@(posedge clk) disable iff (rst)
        ret_q[0] && en_q[0]);

endmodule

// File: rtl/sbpg_stall.sv
module sbpg_stall #(
    parameter int STALL_CYCLES = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic chg,
    output logic stall
);
    localparam int CW = $clog2(STALL_CYCLES + 1);
    localparam logic [CW-1:0] RELOAD = CW'(STALL_CYCLES - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (chg) begin
            cnt <= RELOAD;
        end else if (cnt != '0) begin
            cnt <= cnt - CW'(1);
        end
    end

    assign stall = chg || (cnt != '0);

    p_chg_stalls_r5: assert property (@(posedge clk) disable iff (rst)
        chg |-> stall);

    p_cnt_bound_r6: assert property (@(posedge clk) disable iff (rst)
        cnt <= RELOAD);

endmodule

// File: rtl/sbpg_gate.sv
module sbpg_gate
    import sbpg_pkg::*;
#(
    parameter int NB   = SB_BANKS,
    parameter int B_AW = SB_BANK_AW,
    parameter int DW   = SB_DATA_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NB-1:0]       en_eff,
    input  logic                stall,
    input  logic                bus_req,
    input  logic                bus_we,
    input  logic [B_AW+$clog2(NB)-1:0] bus_addr,
    input  logic [DW-1:0]       bus_wdata,
    output logic [DW-1:0]       bus_rdata,
    output logic                mem_req,
    output logic                mem_we,
    output logic [B_AW+$clog2(NB)-1:0] mem_addr,
    output logic [DW-1:0]       mem_wdata,
    input  logic [DW-1:0]       mem_rdata
);
    localparam int SW = $clog2(NB);

    logic [SW-1:0] bank;
    acc_t          acc;
    logic          pass_q;

    assign bank    = bus_addr[B_AW +: SW];
    assign acc.hit = en_eff[bank];
    assign acc.rd  = bus_req && !bus_we;
    assign acc.wr  = bus_req && bus_we;

    assign mem_req   = (acc.rd || acc.wr) && acc.hit && !stall;
    assign mem_we    = bus_we;
    assign mem_addr  = bus_addr;
    assign mem_wdata = bus_wdata;

    always_ff @(posedge clk) begin
        if (rst) pass_q <= 1'b0;
        else     pass_q <= acc.rd && acc.hit && !stall;
    end

    assign bus_rdata = pass_q ? mem_rdata : '0;

    p_no_mem_in_stall_r7: assert property (@(posedge clk) disable iff (rst)
        stall |-> !mem_req);

    p_blank_read_r8: assert property (@(posedge clk) disable iff (rst)
        (bus_req && !bus_we && !en_eff[bank]) |=> (bus_rdata == '0));

    p_drop_write_r9: assert property (@(posedge clk) disable iff (rst)
        (bus_req && bus_we && !en_eff[bank]) |-> !mem_req);

endmodule

// File: rtl/sbpg_ctrl.sv
module sbpg_ctrl
    import sbpg_pkg::*;
#(
    parameter int NUM_BANKS    = SB_BANKS,
    parameter int BANK_AW      = SB_BANK_AW,
    parameter int DATA_W       = SB_DATA_W,
    parameter int STALL_CYCLES = SB_STALL,
    localparam int ADDR_W      = BANK_AW + $clog2(NUM_BANKS)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 reg_wr,
    input  logic [1:0]           reg_addr,
    input  logic [NUM_BANKS-1:0] reg_wdata,
    output logic [DATA_W-1:0]    reg_rdata,
    input  logic                 lp_deep,
    input  logic                 bus_req,
    input  logic                 bus_we,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic [DATA_W-1:0]    bus_rdata,
    output logic                 bus_stall,
    output logic                 mem_req,
    output logic                 mem_we,
    output logic [ADDR_W-1:0]    mem_addr,
    output logic [DATA_W-1:0]    mem_wdata,
    input  logic [DATA_W-1:0]    mem_rdata,
    output logic [NUM_BANKS-1:0] bank_pwr,
    output logic [NUM_BANKS-1:0] bank_ret
);
    logic [NUM_BANKS-1:0] en_eff, ret_eff;
    logic                 en_chg;

    sbpg_regs #(.NB(NUM_BANKS), .DW(DATA_W)) u_regs (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .busy(bus_stall), .en_eff(en_eff),
        .ret_eff(ret_eff), .en_chg(en_chg), .reg_rdata(reg_rdata)
    );

    sbpg_stall #(.STALL_CYCLES(STALL_CYCLES)) u_stall (
        .clk(clk), .rst(rst), .chg(en_chg), .stall(bus_stall)
    );

    sbpg_gate #(.NB(NUM_BANKS), .B_AW(BANK_AW), .DW(DATA_W)) u_gate (
        .clk(clk), .rst(rst), .en_eff(en_eff), .stall(bus_stall),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata)
    );

    assign bank_pwr = lp_deep ? ret_eff : en_eff;
    assign bank_ret = ret_eff;

    p_ret_in_en_r3: assert property (@(posedge clk) disable iff (rst)
        (bank_ret & ~en_eff) == '0);

    p_off_stays_off_r11: assert property (@(posedge clk) disable iff (rst)
        (bank_pwr & ~en_eff) == '0);

    p_bank0_live_r12: assert property (@(posedge clk) disable iff (rst)
        bank_pwr[0] && bank_ret[0]);

endmodule

// File: tb/tb_sbpg_ctrl.sv
module tb_sbpg_ctrl;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [7:0]  reg_wdata = 8'd0;
    logic [31:0] reg_rdata;
    logic        lp_deep = 1'b0;
    logic        bus_req = 1'b0, bus_we = 1'b0;
    logic [15:0] bus_addr = 16'd0;
    logic [31:0] bus_wdata = 32'd0, bus_rdata;
    logic        bus_stall, mem_req, mem_we;
    logic [15:0] mem_addr;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata = 32'd0;
    logic [7:0]  bank_pwr, bank_ret;

    int errors = 0, checks = 0, reqs = 0, cycles = 0;
    bit done = 0;
    logic [31:0] mem [256];

    always #(CLK_PERIOD/2) clk = ~clk;

    sbpg_ctrl dut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .lp_deep(lp_deep),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_stall(bus_stall),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .bank_pwr(bank_pwr), .bank_ret(bank_ret)
    );

    initial for (int i = 0; i < 256; i++) mem[i] = 32'hC0DE_0000 + 32'(i);

    always @(posedge clk) begin
        if (mem_req) begin
            reqs <= reqs + 1;
            if (mem_we) mem[{mem_addr[15:13], mem_addr[6:2]}] <= mem_wdata;
            else        mem_rdata <= mem[{mem_addr[15:13], mem_addr[6:2]}];
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [1:0] a, output logic [31:0] d);
        reg_addr = a; #1; d = reg_rdata;
    endtask

    task automatic bus_op(input logic we, input logic [15:0] a, input logic [31:0] d);
        bus_req = 1'b1; bus_we = we; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_req = 1'b0; bus_we = 1'b0;
    endtask

    task automatic settle();
        repeat (6) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd_reg(2'd2, v);
        chk("R1 status", v, 32'h0000_0101);
        chk("R4 status after reset", {15'd0, v[16]}, 16'd0);
        chk("R1 stall", {31'd0, bus_stall}, 32'd0);
        chk("R1 bank_pwr", {24'd0, bank_pwr}, 32'h01);
        chk("R1 bank_ret", {24'd0, bank_ret}, 32'h01);
    endtask

    task automatic t_normalise();
        logic [31:0] v;
        wr_reg(2'd0, 8'h00);
        rd_reg(2'd0, v);
        chk("R2 write zero", v, 32'h01);
        chk("R5 no change no stall", {31'd0, bus_stall}, 32'd0);
        wr_reg(2'd0, 8'h20);
        rd_reg(2'd0, v);
        chk("R2 fill down", v, 32'h3F);
        for (int i = 0; i < 4; i++) begin
            chk("R5 stall high", {31'd0, bus_stall}, 32'd1);
            @(negedge clk);
        end
        chk("R5 stall ends", {31'd0, bus_stall}, 32'd0);
        wr_reg(2'd0, 8'h21);
        chk("R5 same vector no stall", {31'd0, bus_stall}, 32'd0);
    endtask

    task automatic t_restart();
        wr_reg(2'd0, 8'h04);
        @(negedge clk);
        wr_reg(2'd0, 8'hFF);
        for (int i = 0; i < 4; i++) begin
            chk("R6 restarted stall", {31'd0, bus_stall}, 32'd1);
            @(negedge clk);
        end
        chk("R6 stall ends after restart", {31'd0, bus_stall}, 32'd0);
    endtask

    task automatic t_stall_block();
        int r0;
        logic [31:0] v;
        wr_reg(2'd0, 8'h01);
        rd_reg(2'd2, v);
        chk("R4 busy bit", {31'd0, v[16]}, 32'd1);
        r0 = reqs;
        bus_req = 1'b1; bus_we = 1'b0; bus_addr = 16'h0010; #1;
        chk("R7 mem_req in stall", {31'd0, mem_req}, 32'd0);
        @(negedge clk);
        bus_req = 1'b0;
        chk("R7 no array access", 32'(reqs - r0), 32'd0);
        settle();
    endtask

    task automatic t_enabled_access();
        int r0;
        r0 = reqs;
        bus_req = 1'b1; bus_we = 1'b1; bus_addr = 16'h0010; bus_wdata = 32'hA5A5_5A5A; #1;
        chk("R10 mem_addr", {16'd0, mem_addr}, 32'h0010);
        chk("R10 mem_wdata", mem_wdata, 32'hA5A5_5A5A);
        @(negedge clk);
        bus_req = 1'b0; bus_we = 1'b0;
        bus_op(1'b0, 16'h0010, 32'd0);
        chk("R10 read back", bus_rdata, 32'hA5A5_5A5A);
        chk("R10 access count", 32'(reqs - r0), 32'd2);
    endtask

    task automatic t_disabled_bank();
        int r0;
        r0 = reqs;
        bus_op(1'b1, 16'h6000, 32'h1234_5678);
        chk("R9 write dropped", 32'(reqs - r0), 32'd0);
        bus_op(1'b0, 16'h6000, 32'd0);
        chk("R8 read blank", bus_rdata, 32'd0);
        chk("R8 no array read", 32'(reqs - r0), 32'd0);
        wr_reg(2'd0, 8'h08);
        settle();
        bus_op(1'b0, 16'h6000, 32'd0);
        chk("R9 array unchanged", bus_rdata, 32'hC0DE_0060);
    endtask

    task automatic t_retention();
        logic [31:0] v;
        wr_reg(2'd1, 8'hFF);
        rd_reg(2'd2, v);
        chk("R3 retention masked", {24'd0, v[15:8]}, 32'h0F);
        chk("R12 bank_ret", {24'd0, bank_ret}, 32'h0F);
        wr_reg(2'd1, 8'h00);
        rd_reg(2'd1, v);
        chk("R3 bank0 kept", v, 32'h01);
        chk("R12 bank0 retained", {24'd0, bank_ret}, 32'h01);
    endtask

    task automatic t_deep();
        logic [31:0] v;
        wr_reg(2'd1, 8'h85);
        lp_deep = 1'b1; #1;
        chk("R11 deep power", {24'd0, bank_pwr}, 32'h05);
        lp_deep = 1'b0; #1;
        chk("R11 active power", {24'd0, bank_pwr}, 32'h0F);
        wr_reg(2'd0, 8'h10);
        rd_reg(2'd2, v);
        chk("R4 status layout", v, 32'h0001_051F);
        settle();
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 20000 && !done) begin
            done = 1;
            errors++; checks++;
            $display("FAIL watchdog: actual=%0d expected=<20000", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_normalise();
        t_restart();
        t_stall_block();
        t_enabled_access();
        t_disabled_bank();
        t_retention();
        t_deep();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule